// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Cascaded Clock Dividers

This block produces `NCH` independent pulse-width modulated outputs, each set up through a plain register port. Channels are grouped in pairs. Each pair has one clock setting. That setting picks one of two clock-enable strobes, one from a fast oscillator and one from the bus clock, and divides the chosen strobe by a power of two. Each channel then divides that pair strobe again with its own 8-bit prescaler. The result steps a 16-bit counter. The counter sets the length of a period and compares against an active length to shape the pulse.

All logic runs on one clock. The two clock sources reach the block as single-cycle enable strobes, so no second clock domain exists inside it. Each channel has its own bits for enable, gate, bypass and active level. A new period or active length is held in a shadow copy until the running period ends, so a period in progress is never cut short. The register port has no flow control: a write takes effect at the clock edge on which `reg_we` is high, and `reg_rdata` is a combinational view of the addressed register.

Top module: `pwm_array`

## Requirements
- R1: After reset, every register reads 0. Every output is at its inactive level, which is high because the active-level bit resets to 0.
- R2: Register readback is as follows. Pair clock word at 0x20+4·pair: bits [8:7] source select, bits [3:0] exponent m. Gate word at 0x40: bit ch is the gate, bit ch+16 is the bypass. Enable word at 0x80: bit ch. Control word at 0x100+0x20·ch: bit 8 is the active level, bits [7:0] are prescaler k. Period word at 0x104+0x20·ch: bits [31:16] entire count, bits [15:0] active count. Unused bits read 0.
- R3: With the channel enabled and its gate bit at 1, one period lasts E·(k+1)·2^m selected source strobes, where E is the entire count (0 counts as 1). The output is active while the counter is below the active count.
- R4: An active count larger than the entire count keeps the output active for the whole period.
- R5: Active-level bit 1 makes the active phase drive high. Bit 0 makes it drive low.
- R6: Source select 0 takes the oscillator strobe. Any other value takes the bus strobe.
- R7: An exponent m from 9 to 15 divides exactly as m = 8. The stored value still reads back unchanged.
- R8: Both channels of a pair, 2p and 2p+1, use the clock word of pair p.
- R9: A channel whose enable bit is 0 drives its inactive level in the cycle after the write.
- R10: A channel whose gate bit is 0 receives no strobes, so its output holds its level.
- R11: With the bypass bit set, the output is a square wave that toggles on every prescaled strobe, with period 2·(k+1)·2^m strobes. The counter compare has no effect.
- R12: A period or active count written while the channel runs takes effect only at the next period boundary. A write that lands on the boundary edge itself takes effect one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator clock-enable strobe |
| bus_tick | input | 1 | Bus clock-enable strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| pwm_out | output | NCH | One modulated output per channel |

## Verification
Two functions can fall in the same cycle: a software write of a new period word, and the period wrap that reloads the shadow copy. The bench first writes mid-period and checks that the remaining runs of the old period stay intact before the new lengths appear. It then counts output samples up to the last cycle of a period and times the write so it is registered on the wrap edge. The check passes only if one further complete old period (10 high, 10 low) comes before the new 3/3 pattern.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int PSC_W     = 8;
  localparam int EXP_W     = 4;
  localparam int EXP_MAX   = 8;
  localparam int DIV_W     = EXP_MAX;

  localparam logic [ADDR_W-1:0] CLK_BASE  = 12'h020;
  localparam logic [ADDR_W-1:0] CLK_STEP  = 12'h004;
  localparam logic [ADDR_W-1:0] GATE_ADDR = 12'h040;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 12'h080;
  localparam logic [ADDR_W-1:0] CTL_BASE  = 12'h100;
  localparam logic [ADDR_W-1:0] PER_OFS   = 12'h004;
  localparam logic [ADDR_W-1:0] CH_STEP   = 12'h020;
  localparam int BYP_SHIFT = 16;

  typedef struct packed {
    logic               en;
    logic               gate;
    logic               byp;
    logic               pol;
    logic [PSC_W-1:0]   k;
    logic [CNT_W-1:0]   ent;
    logic [CNT_W-1:0]   act;
  } chan_cfg_t;

  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] m);
    return (m > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : m;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output chan_cfg_t         cfg [NCH],
  output logic              pair_bus [(NCH+1)/2],
  output logic [EXP_W-1:0]  pair_exp [(NCH+1)/2]
);
  localparam int NPAIR = (NCH + 1) / 2;

  logic [1:0]       src_q [NPAIR];
  logic [EXP_W-1:0] exp_q [NPAIR];
  logic [NCH-1:0]   en_q, gate_q, byp_q;
  logic [8:0]       ctl_q [NCH];
  logic [DATA_W-1:0] per_q [NCH];

  function automatic logic [ADDR_W-1:0] ctl_addr(input int ch);
    return CTL_BASE + ADDR_W'(ch) * CH_STEP;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      gate_q <= '0;
      byp_q  <= '0;
      for (int p = 0; p < NPAIR; p++) begin
        src_q[p] <= '0;
        exp_q[p] <= '0;
      end
      for (int c = 0; c < NCH; c++) begin
        ctl_q[c] <= '0;
        per_q[c] <= '0;
      end
    end else if (reg_we) begin
      if (reg_addr == EN_ADDR) en_q <= reg_wdata[NCH-1:0];
      if (reg_addr == GATE_ADDR) begin
        gate_q <= reg_wdata[NCH-1:0];
        byp_q  <= reg_wdata[BYP_SHIFT +: NCH];
      end
      for (int p = 0; p < NPAIR; p++) begin
        if (reg_addr == CLK_BASE + ADDR_W'(p) * CLK_STEP) begin
          src_q[p] <= reg_wdata[8:7];
          exp_q[p] <= reg_wdata[EXP_W-1:0];
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == ctl_addr(c))           ctl_q[c] <= reg_wdata[8:0];
        if (reg_addr == ctl_addr(c) + PER_OFS) per_q[c] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == EN_ADDR) reg_rdata[NCH-1:0] = en_q;
    if (reg_addr == GATE_ADDR) begin
      reg_rdata[NCH-1:0]          = gate_q;
      reg_rdata[BYP_SHIFT +: NCH] = byp_q;
    end
    for (int p = 0; p < NPAIR; p++) begin
      if (reg_addr == CLK_BASE + ADDR_W'(p) * CLK_STEP) begin
        reg_rdata[8:7]       = src_q[p];
        reg_rdata[EXP_W-1:0] = exp_q[p];
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == ctl_addr(c))           reg_rdata[8:0] = ctl_q[c];
      if (reg_addr == ctl_addr(c) + PER_OFS) reg_rdata      = per_q[c];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_bus[p] = |src_q[p];
    assign pair_exp[p] = exp_q[p];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign cfg[c] = '{en:   en_q[c],
                      gate: gate_q[c],
                      byp:  byp_q[c],
                      pol:  ctl_q[c][8],
                      k:    ctl_q[c][7:0],
                      ent:  per_q[c][31:16],
                      act:  per_q[c][15:0]};
  end

  assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == EN_ADDR |=> en_q == $past(reg_wdata[NCH-1:0]));
endmodule

// File: rtl/pwm_pair_div.sv
module pwm_pair_div
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             bus_tick,
  input  logic             sel_bus,
  input  logic [EXP_W-1:0] exp_raw,
  output logic             div_tick
);
  logic [DIV_W-1:0] acc;
  logic [EXP_W-1:0] m_eff;
  logic [DIV_W-1:0] mask;
  logic             src_tick;

  assign src_tick = sel_bus ? bus_tick : osc_tick;
  assign m_eff    = clamp_exp(exp_raw);
  assign mask     = DIV_W'((9'd1 << m_eff) - 9'd1);
  assign div_tick = src_tick && ((acc & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)        acc <= '0;
    else if (src_tick) acc <= acc + 1'b1;
  end

  assert_div_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick && m_eff != 0 |=> !div_tick || m_eff != $past(m_eff));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  input  logic      pair_tick,
  output logic      pin
);
  logic [PSC_W-1:0] pk;
  logic [CNT_W-1:0] cnt, sh_ent, sh_act, last;
  logic             tgl, step_in, ptick, at_last, active;

  assign step_in = cfg.en && cfg.gate && pair_tick;
  assign ptick   = step_in && (pk >= cfg.k);
  assign last    = (sh_ent == '0) ? '0 : sh_ent - 1'b1;
  assign at_last = cnt >= last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk <= '0; cnt <= '0; tgl <= 1'b0;
      sh_ent <= '0; sh_act <= '0;
    end else if (!cfg.en) begin
      pk <= '0; cnt <= '0; tgl <= 1'b0;
      sh_ent <= cfg.ent; sh_act <= cfg.act;
    end else begin
      if (step_in) pk <= ptick ? '0 : pk + 1'b1;
      if (ptick) begin
        tgl <= ~tgl;
        if (at_last) begin
          cnt    <= '0;
          sh_ent <= cfg.ent;
          sh_act <= cfg.act;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign active = cfg.byp ? tgl : (cnt < sh_act);
  assign pin    = (cfg.en && active) ? cfg.pol : ~cfg.pol;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.en && sh_ent != '0 |-> cnt < sh_ent);
  assert_shadow_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.en && !(ptick && at_last) ##1 cfg.en |-> $stable(sh_ent) && $stable(sh_act));
  assert_gate_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.en && !cfg.gate ##1 cfg.en |-> $stable(cnt) && $stable(tgl));
  assert_bypass_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.en && !ptick ##1 cfg.en |-> $stable(tgl));
endmodule

// File: rtl/pwm_array.sv
module pwm_array
  import pwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int NPAIR = (NCH + 1) / 2;

  chan_cfg_t        cfg      [NCH];
  logic             pair_bus [NPAIR];
  logic [EXP_W-1:0] pair_exp [NPAIR];
  logic             pair_tk  [NPAIR];

  pwm_regs #(.NCH(NCH)) regs_i (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .cfg(cfg), .pair_bus(pair_bus), .pair_exp(pair_exp)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_pair_div div_i (
      .clk, .rst_n, .osc_tick, .bus_tick,
      .sel_bus(pair_bus[p]), .exp_raw(pair_exp[p]), .div_tick(pair_tk[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_chan chan_i (
      .clk, .rst_n, .cfg(cfg[c]), .pair_tick(pair_tk[c/2]), .pin(pwm_out[c])
    );
  end
endmodule

// File: tb/pwm_array_tb_top.sv
module pwm_array_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        osc_tick = 1'b1, bus_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] pwm_out;

  int total = 0, bad = 0;
  bit done = 0;

  pwm_array #(.NCH(NCH)) dut_i (.*);

  always #5 clk = ~clk;
  always @(negedge clk) bus_tick <= ~bus_tick;

  typedef struct packed {
    logic [3:0]  ch;
    logic        src;
    logic [3:0]  m;
    logic [7:0]  k;
    logic        pol;
    logic [15:0] ent;
    logic [15:0] act;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0, 1'b0, 4'd0,  8'd0, 1'b1, 16'd10, 16'd3},
    '{4'd1, 1'b0, 4'd0,  8'd2, 1'b1, 16'd8,  16'd5},
    '{4'd2, 1'b1, 4'd1,  8'd0, 1'b1, 16'd6,  16'd2},
    '{4'd3, 1'b1, 4'd2,  8'd1, 1'b0, 16'd5,  16'd4},
    '{4'd0, 1'b0, 4'd12, 8'd0, 1'b1, 16'd4,  16'd1},
    '{4'd1, 1'b0, 4'd3,  8'd0, 1'b1, 16'd5,  16'd9},
    '{4'd0, 1'b0, 4'd0,  8'd0, 1'b0, 16'd7,  16'd0},
    '{4'd3, 1'b0, 4'd0,  8'd0, 1'b1, 16'd0,  16'd1}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic count_ones(input int ch, input int w, output int n);
    n = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      n += pwm_out[ch];
    end
  endtask

  task automatic run_len(input int ch, input logic v, output int n);
    n = 0;
    while (pwm_out[ch] == v && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, h1, l1, h2, l2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_chk("R1 en", 12'h080, 32'h0);
    rd_chk("R1 gate", 12'h040, 32'h0);
    rd_chk("R1 clk", 12'h020, 32'h0);
    rd_chk("R1 ctl", 12'h120, 32'h0);
    rd_chk("R1 per", 12'h164, 32'h0);
    chk("R1 pins", pwm_out, 4'hF);

    // R2: readback and unused bits
    wr(12'h120, 32'hFFFF_FFFF);
    rd_chk("R2 ctl", 12'h120, 32'h0000_01FF);
    wr(12'h144, 32'hABCD_1234);
    rd_chk("R2 per", 12'h144, 32'hABCD_1234);
    wr(12'h024, 32'hFFFF_FFFF);
    rd_chk("R2 clk", 12'h024, 32'h0000_018F);
    wr(12'h040, 32'hFFFF_FFFF);
    rd_chk("R2 gate", 12'h040, 32'h000F_000F);
    wr(12'h080, 32'hFFFF_FFFF);
    rd_chk("R2 en", 12'h080, 32'h0000_000F);
    wr(12'h080, 32'h0);
    wr(12'h040, 32'h0);
    // R7: reserved exponent reads back as written
    wr(12'h020, 32'h0000_000C);
    rd_chk("R7 readback", 12'h020, 32'h0000_000C);

    // Table of duty vectors: R3 R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic longint unit = longint'(v.k + 1) * (longint'(1) << ((v.m > 8) ? 8 : v.m)) * (v.src ? 2 : 1);
      automatic longint ent_e = (v.ent == 0) ? 1 : v.ent;
      automatic longint act_e = (v.act > ent_e) ? ent_e : v.act;
      automatic longint per = ent_e * unit;
      automatic longint w = 2 * per;
      automatic longint on_clk = 2 * act_e * unit;
      automatic longint exp_ones = v.pol ? on_clk : w - on_clk;
      wr(12'h080, 32'h0);
      wr(12'h020 + 12'(v.ch / 2) * 12'h4, (32'(v.src) << 7) | 32'(v.m));
      wr(12'h040, 32'h1 << v.ch);
      wr(12'h100 + 12'(v.ch) * 12'h20, (32'(v.pol) << 8) | 32'(v.k));
      wr(12'h104 + 12'(v.ch) * 12'h20, {v.ent, v.act});
      wr(12'h080, 32'h1 << v.ch);
      repeat (int'(2 * per + 10)) @(negedge clk);
      count_ones(v.ch, int'(w), n);
      chk($sformatf("R3 R4 R5 R6 R7 R8 vector %0d", i), n, exp_ones);
    end

    // R9: disable drives inactive level (ch3 active high, running always active)
    chk("R9 pre", pwm_out[3], 1'b1);
    wr(12'h080, 32'h0);
    chk("R9 disabled", pwm_out[3], 1'b0);

    // R10: gate off freezes the output
    wr(12'h020, 32'h0);
    wr(12'h100, 32'h100);
    wr(12'h104, {16'd20, 16'd10});
    wr(12'h040, 32'h1);
    wr(12'h080, 32'h1);
    repeat (7) @(negedge clk);
    wr(12'h040, 32'h0);
    n = 0;
    begin
      automatic logic p0 = pwm_out[0];
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (pwm_out[0] != p0) n++;
      end
    end
    chk("R10 changes while gated", n, 0);

    // R11: bypass square wave, counter ignored (compare alone would stay active)
    wr(12'h080, 32'h0);
    wr(12'h100, 32'h101);
    wr(12'h104, {16'd3, 16'd3});
    wr(12'h040, 32'h0001_0001);
    wr(12'h080, 32'h1);
    repeat (10) @(negedge clk);
    count_ones(0, 40, n);
    chk("R11 bypass ones", n, 20);

    // R12: write mid-period, takes effect at boundary
    wr(12'h080, 32'h0);
    wr(12'h040, 32'h1);
    wr(12'h100, 32'h100);
    wr(12'h104, {16'd20, 16'd10});
    wr(12'h080, 32'h1);
    @(negedge clk);
    while (pwm_out[0] != 1'b0) @(negedge clk);
    while (pwm_out[0] != 1'b1) @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h104; reg_wdata = {16'd6, 16'd3};
    @(negedge clk);
    reg_we = 1'b0;
    run_len(0, 1'b1, h1); run_len(0, 1'b0, l1);
    run_len(0, 1'b1, h2); run_len(0, 1'b0, l2);
    chk("R12 rest of old high", h1, 9);
    chk("R12 old low", l1, 10);
    chk("R12 new high", h2, 3);
    chk("R12 new low", l2, 3);

    // R12: write landing on the wrap edge
    wr(12'h104, {16'd20, 16'd10});
    repeat (40) @(negedge clk);
    while (pwm_out[0] != 1'b1) @(negedge clk);
    while (pwm_out[0] != 1'b0) @(negedge clk);
    repeat (9) @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h104; reg_wdata = {16'd6, 16'd3};
    @(negedge clk);
    reg_we = 1'b0;
    run_len(0, 1'b1, h1); run_len(0, 1'b0, l1);
    run_len(0, 1'b1, h2); run_len(0, 1'b0, l2);
    chk("R12 collide old high", h1, 10);
    chk("R12 collide old low", l1, 10);
    chk("R12 collide new high", h2, 3);
    chk("R12 collide new low", l2, 3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule